// File: doc/BRIEF.md
# External Bus Single-Transfer Master

This block runs one read or one write at a time on an asynchronous-style external bus. It runs from a core clock at twice the bus rate and produces the bus clock itself by toggling a register on every core edge. Each core cycle is therefore one half of a bus clock. A transfer moves through six phases, S0 to S5, and each phase lasts one core cycle. Phases S0, S2 and S4 are the high halves of the bus clock, and S1, S3 and S5 are the low halves. This makes each rising or falling bus-clock edge an ordinary synchronous step of the state machine.

Requesting logic presents the following with `req_i`:
- an address
- a transfer size
- the direction
- write data
- a termination mode and a wait count

The request is taken on a core edge when `ready_o` is high. The block then drives the address, read/write, size, start strobe, in-progress, chip select, byte strobes and output enable. It waits for acknowledge. On a read it latches the data, then closes the cycle. Acknowledge can come from the external device on `ta_n_i`, or the block can generate it internally after a programmed number of wait-state pairs. Internal acknowledge appears on `ta_int_n_o` with the same shape an external device would give. A new request may be taken in S5, so the next S0 starts on the very edge that ends the current transfer.

Top module: `ebm_master`

## Requirements
- R1: After reset every active-low strobe (`ts_n_o`, `tip_n_o`, `cs_n_o`, `be_n_o`, `oe_n_o`, `ta_int_n_o`) is high. `addr_oe_o` and `data_oe_o` are low. `addr_o`, `siz_o` and `data_o` read 0 and `rnw_o` reads 1. `bus_clk_o` is low in the first core cycle after reset and inverts every core cycle.
- R2: `ready_o` is high only when the block is idle and `bus_clk_o` is low, or when it is in S5. A request present while `ready_o` is high is taken on that edge, and the next core cycle is S0 with `bus_clk_o` high.
- R3: From S0 through S5 the block drives the captured address on `addr_o` with `addr_oe_o` high. It drives `rnw_o` as 1 for a read and 0 for a write, `siz_o` with the size, and `tip_n_o` low. `ts_n_o` is low in S0 and S1 only, which is exactly one bus clock.
- R4: `cs_n_o` is low from S1 through S4. `oe_n_o` is low in the same phases on reads only. Both go high on entry to S5, a falling bus-clock edge, while `tip_n_o` and the address are still driven.
- R5: `be_n_o` is active low, with bit k standing for byte lane k. It is asserted from S1 through S4 and is all ones otherwise. Size 0 selects lane `addr[1:0]`. Size 1 selects lanes 0 and 1 when `addr[1]` is 0, and lanes 2 and 3 when it is 1. Sizes 2 and 3 select all four lanes.
- R6: In external mode `ta_n_i` is sampled only on the edge that ends S3. If it is high there, one more S2/S3 pair follows. A low `ta_n_i` at any other time has no effect.
- R7: On a read, `data_i` is captured on the edge that ends the terminating S3. `rvalid_o` is high during S4 and `rdata_o` keeps the captured value until the next read.
- R8: In internal mode with wait count W (0 to 15), exactly W extra S2/S3 pairs run before the terminating S3, and `ta_n_i` is ignored. `ta_int_n_o` is low in the terminating S3 and in S4 only. In external mode `ta_int_n_o` stays high and the wait count is ignored.
- R9: `done_o` is high during S5 only. On the edge that ends S5, unless a new request is taken, the address and `rnw_o` are released, `tip_n_o` goes high, `siz_o` returns to 0 and `data_oe_o` drops.
- R10: A request taken in S5 makes the next core cycle S0 of the new transfer, with no idle cycle in between.
- R11: On a write, `data_o` carries the write data with `data_oe_o` high from S1 through S5, and `oe_n_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request |
| req_addr_i | input | AW | Request address |
| req_size_i | input | SW | Size: 0 byte, 1 half, 2/3 full word |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW | Write data |
| req_int_term_i | input | 1 | 1 = internal termination |
| req_wait_i | input | WCW | Internal wait-pair count |
| ready_o | output | 1 | Request can be taken this cycle |
| done_o | output | 1 | High in S5 |
| rvalid_o | output | 1 | Read data valid (S4 of a read) |
| rdata_o | output | DW | Latched read data |
| bus_clk_o | output | 1 | Generated bus clock |
| addr_o | output | AW | Bus address |
| addr_oe_o | output | 1 | Address and R/W drive enable |
| rnw_o | output | 1 | 1 = read, 0 = write |
| siz_o | output | SW | Transfer size lines |
| ts_n_o | output | 1 | Start strobe, active low |
| tip_n_o | output | 1 | Transfer in progress, active low |
| cs_n_o | output | 1 | Chip select, active low |
| be_n_o | output | DW/8 | Byte strobes, active low |
| oe_n_o | output | 1 | Output enable, active low |
| data_o | output | DW | Write data out |
| data_oe_o | output | 1 | Write data drive enable |
| data_i | input | DW | Read data in |
| ta_n_i | input | 1 | External acknowledge, active low |
| ta_int_n_o | output | 1 | Internally generated acknowledge, active low |

## Verification
The embedded properties watch the following on every cycle:
- the start strobe begins on a rising bus edge and lasts exactly two core cycles;
- chip select lifts while in-progress is still low;
- in-progress lifts only after the address has been released;
- output enable and write drive are never active together;
- read-valid is always followed by done;
- the wait counter never underflows.

Only the bench scenarios can show the full phase sequence against a reference model. These scenarios also cover:
- the wait-pair count in each termination mode;
- that acknowledge is ignored outside S3 or in internal mode;
- the edge on which read data is captured;
- byte-lane selection for every size and offset;
- back-to-back transfers that begin in S5.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_S0   = 3'd1,
        PH_S1   = 3'd2,
        PH_S2   = 3'd3,
        PH_S3   = 3'd4,
        PH_S4   = 3'd5,
        PH_S5   = 3'd6
    } ebm_phase_e;
endpackage

// File: rtl/ebm_busclk.sv
module ebm_busclk (
    input  logic clk,
    input  logic rst_n,
    output logic bus_clk_o
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = ~tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign bus_clk_o = tog_q;
endmodule

// File: rtl/ebm_wait_ctr.sv
module ebm_wait_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)     cnt_d = load_val_i;
        else if (dec_i) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R8
    wait_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> !zero_o);

    // R8
    wait_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/ebm_lane_dec.sv
module ebm_lane_dec #(
    parameter int NL = 4,
    parameter int SW = 2,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic [LW-1:0] lsb_i,
    input  logic [SW-1:0] size_i,
    output logic [NL-1:0] mask_o
);
    for (genvar k = 0; k < NL; k++) begin : g_lane
        localparam logic [LW-1:0] KIDX = LW'(k);
        logic byte_hit, half_hit;
        assign byte_hit = (lsb_i == KIDX);
        if (LW >= 2) begin : g_half
            assign half_hit = (lsb_i[LW-1:1] == KIDX[LW-1:1]);
        end else begin : g_half1
            assign half_hit = 1'b1;
        end
        assign mask_o[k] = (size_i == SW'(0)) ? byte_hit :
                           (size_i == SW'(1)) ? half_hit : 1'b1;
    end
endmodule

// File: rtl/ebm_master.sv
module ebm_master #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SW  = 2,
    parameter int WCW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [AW-1:0]   req_addr_i,
    input  logic [SW-1:0]   req_size_i,
    input  logic            req_write_i,
    input  logic [DW-1:0]   req_wdata_i,
    input  logic            req_int_term_i,
    input  logic [WCW-1:0]  req_wait_i,
    output logic            ready_o,
    output logic            done_o,
    output logic            rvalid_o,
    output logic [DW-1:0]   rdata_o,
    output logic            bus_clk_o,
    output logic [AW-1:0]   addr_o,
    output logic            addr_oe_o,
    output logic            rnw_o,
    output logic [SW-1:0]   siz_o,
    output logic            ts_n_o,
    output logic            tip_n_o,
    output logic            cs_n_o,
    output logic [DW/8-1:0] be_n_o,
    output logic            oe_n_o,
    output logic [DW-1:0]   data_o,
    output logic            data_oe_o,
    input  logic [DW-1:0]   data_i,
    input  logic            ta_n_i,
    output logic            ta_int_n_o
);
    import ebm_pkg::*;

    localparam int NL = DW / 8;
    localparam int LW = (NL > 1) ? $clog2(NL) : 1;

    typedef struct packed {
        ebm_phase_e     ph;
        logic [AW-1:0]  addr;
        logic [SW-1:0]  size;
        logic           wr;
        logic [DW-1:0]  wdata;
        logic           intm;
        logic [DW-1:0]  rdata;
    } xfer_t;

    xfer_t   x_d, x_q;
    logic    bus_clk;
    logic    cnt_zero;
    logic    accept, term, ctr_dec;
    logic [NL-1:0] lane_mask;

    ebm_busclk u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_clk_o (bus_clk)
    );

    ebm_wait_ctr #(.CW(WCW)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (req_wait_i),
        .dec_i      (ctr_dec),
        .zero_o     (cnt_zero)
    );

    ebm_lane_dec #(.NL(NL), .SW(SW)) u_lane (
        .lsb_i  (x_q.addr[LW-1:0]),
        .size_i (x_q.size),
        .mask_o (lane_mask)
    );

    assign ready_o = ((x_q.ph == PH_IDLE) && !bus_clk) || (x_q.ph == PH_S5);
    assign accept  = req_i && ready_o;
    assign term    = x_q.intm ? cnt_zero : !ta_n_i;
    assign ctr_dec = (x_q.ph == PH_S3) && x_q.intm && !cnt_zero;

    always_comb begin
        x_d = x_q;
        unique case (x_q.ph)
            PH_IDLE: ;
            PH_S0:   x_d.ph = PH_S1;
            PH_S1:   x_d.ph = PH_S2;
            PH_S2:   x_d.ph = PH_S3;
            PH_S3: begin
                if (term) begin
                    x_d.ph = PH_S4;
                    if (!x_q.wr) x_d.rdata = data_i;
                end else begin
                    x_d.ph = PH_S2;
                end
            end
            PH_S4:   x_d.ph = PH_S5;
            PH_S5:   x_d.ph = PH_IDLE;
            default: x_d.ph = PH_IDLE;
        endcase
        if (accept) begin
            x_d.ph    = PH_S0;
            x_d.addr  = req_addr_i;
            x_d.size  = req_size_i;
            x_d.wr    = req_write_i;
            x_d.wdata = req_wdata_i;
            x_d.intm  = req_int_term_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q      <= '0;
            x_q.ph   <= PH_IDLE;
        end else begin
            x_q      <= x_d;
        end
    end

    logic in_xfer, strobe_win, ts_win;

    always_comb begin
        in_xfer    = (x_q.ph != PH_IDLE);
        strobe_win = (x_q.ph == PH_S1) || (x_q.ph == PH_S2) ||
                     (x_q.ph == PH_S3) || (x_q.ph == PH_S4);
        ts_win     = (x_q.ph == PH_S0) || (x_q.ph == PH_S1);

        bus_clk_o  = bus_clk;
        addr_oe_o  = in_xfer;
        addr_o     = in_xfer ? x_q.addr : '0;
        rnw_o      = in_xfer ? !x_q.wr : 1'b1;
        siz_o      = in_xfer ? x_q.size : '0;
        tip_n_o    = !in_xfer;
        ts_n_o     = !ts_win;
        cs_n_o     = !strobe_win;
        be_n_o     = strobe_win ? ~lane_mask : '1;
        oe_n_o     = !(strobe_win && !x_q.wr);
        data_oe_o  = x_q.wr && in_xfer && (x_q.ph != PH_S0);
        data_o     = data_oe_o ? x_q.wdata : '0;
        done_o     = (x_q.ph == PH_S5);
        rvalid_o   = (x_q.ph == PH_S4) && !x_q.wr;
        rdata_o    = x_q.rdata;
        ta_int_n_o = !(x_q.intm &&
                       (((x_q.ph == PH_S3) && cnt_zero) || (x_q.ph == PH_S4)));
    end

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ready_o) |=> (!ts_n_o && bus_clk_o && !tip_n_o));

    // R3
    ts_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ts_n_o) |-> bus_clk_o);

    // R3
    ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ts_n_o) |=> !ts_n_o);

    // R3
    ts_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_n_o && $past(!ts_n_o) && !$past(done_o)) |=> ts_n_o);

    // R4
    cs_neg_before_tip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (!tip_n_o && !bus_clk_o && addr_oe_o));

    // R9
    tip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tip_n_o) |-> (!addr_oe_o && !data_oe_o && $past(done_o)));

    // R11
    oe_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_oe_o && !oe_n_o));

    // R7
    rvalid_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> done_o);
endmodule

// File: tb/tb_ebm_master.sv
`timescale 1ns/1ps
module tb_ebm_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [1:0]  req_size_i = '0;
    logic        req_write_i = 1'b0;
    logic [31:0] req_wdata_i = '0;
    logic        req_int_term_i = 1'b0;
    logic [3:0]  req_wait_i = '0;
    logic        ready_o, done_o, rvalid_o, bus_clk_o, addr_oe_o, rnw_o;
    logic [31:0] rdata_o, addr_o, data_o;
    logic [1:0]  siz_o;
    logic        ts_n_o, tip_n_o, cs_n_o, oe_n_o, data_oe_o, ta_int_n_o;
    logic [3:0]  be_n_o;
    logic [31:0] data_i = 32'hBAD0_0000;
    logic        ta_n_i = 1'b1;

    always #2 clk = ~clk;

    ebm_master dut (.*);

    typedef struct {
        int          ph;
        bit          fin;
        int          pairs;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic [31:0] wdata;
        logic        intm;
        logic [31:0] rdat;
        logic        ta_low;
    } cyc_t;

    cyc_t q[$];
    int   n_chk = 0, n_fail = 0;
    int   cyc = 0, since_ts = 0, b2b_seen = 0;
    logic mclk = 1'b0, prev_done = 1'b0, prev_ts = 1'b1, started = 1'b0;
    logic [31:0] last_rd = '0;

    int          tb_ext = 0;
    bit          tb_early = 0, tb_glitch = 0;
    logic [31:0] tb_rdat = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [3:0] lane_mask(logic [1:0] a, logic [1:0] s);
        if (s == 2'd0) return 4'b0001 << a;
        if (s == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    // Reference model and comparison, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && started) begin
            cyc++;
            since_ts++;
            chk(bus_clk_o == mclk, "R1", "bus_clk_o", 32'(bus_clk_o), 32'(mclk));
            if (q.size() == 0) begin
                chk({ts_n_o, tip_n_o, cs_n_o, be_n_o, oe_n_o, ta_int_n_o} == 9'h1FF,
                    "R1", "idle strobes", 32'({ts_n_o, tip_n_o, cs_n_o, be_n_o, oe_n_o, ta_int_n_o}), 32'h1FF);
                chk({addr_oe_o, data_oe_o, rnw_o} == 3'b001 && addr_o == 0 && data_o == 0 && siz_o == 0,
                    "R9", "idle release", {addr_o[27:0], addr_oe_o, data_oe_o, rnw_o, siz_o != 0}, 32'h2);
                chk(!done_o && !rvalid_o, "R9", "idle done/rvalid", 32'({done_o, rvalid_o}), 0);
                ta_n_i = 1'b1;
                data_i = 32'hBAD0_0000 | 32'(cyc);
            end else begin
                cyc_t e;
                bit   sw, rd;
                logic [3:0] m;
                e  = q[0];
                sw = (e.ph >= 1 && e.ph <= 4);
                rd = !e.wr;
                m  = lane_mask(e.addr[1:0], e.size);
                chk(ts_n_o == !(e.ph <= 1), "R3", "ts_n_o", 32'(ts_n_o), 32'(!(e.ph <= 1)));
                chk(!tip_n_o && addr_oe_o, "R3", "tip/addr_oe", 32'({tip_n_o, addr_oe_o}), 32'b01);
                chk(addr_o == e.addr, "R3", "addr_o", addr_o, e.addr);
                chk(rnw_o == rd, "R3", "rnw_o", 32'(rnw_o), 32'(rd));
                chk(siz_o == e.size, "R3", "siz_o", 32'(siz_o), 32'(e.size));
                chk(cs_n_o == !sw, "R4", "cs_n_o", 32'(cs_n_o), 32'(!sw));
                chk(oe_n_o == !(sw && rd), "R4", "oe_n_o", 32'(oe_n_o), 32'(!(sw && rd)));
                chk(be_n_o == (sw ? ~m : 4'hF), "R5", "be_n_o", 32'(be_n_o), 32'(sw ? ~m : 4'hF));
                chk(data_oe_o == (e.wr && e.ph >= 1), "R11", "data_oe_o",
                    32'(data_oe_o), 32'(e.wr && e.ph >= 1));
                if (e.wr && e.ph >= 1)
                    chk(data_o == e.wdata, "R11", "data_o", data_o, e.wdata);
                chk(done_o == (e.ph == 5), "R9", "done_o", 32'(done_o), 32'(e.ph == 5));
                chk(rvalid_o == (e.ph == 4 && rd), "R7", "rvalid_o", 32'(rvalid_o), 32'(e.ph == 4 && rd));
                if (e.ph == 4 && rd) last_rd = e.rdat;
                chk(ta_int_n_o == !(e.intm && ((e.ph == 3 && e.fin) || e.ph == 4)), "R8", "ta_int_n_o",
                    32'(ta_int_n_o), 32'(!(e.intm && ((e.ph == 3 && e.fin) || e.ph == 4))));
                if (done_o)
                    chk(since_ts == 3 + 2 * e.pairs, e.intm ? "R8" : "R6", "cycles S0..S5",
                        32'(since_ts), 32'(3 + 2 * e.pairs));
                ta_n_i = !e.ta_low;
                data_i = (e.ph == 3 && e.fin && rd) ? e.rdat : (32'hBAD0_0000 | 32'(cyc));
            end
            chk(rdata_o == last_rd, "R7", "rdata_o", rdata_o, last_rd);
            if (!ts_n_o && prev_ts) begin
                since_ts = 0;
                if (prev_done) b2b_seen++;
            end
            prev_ts   = ts_n_o;
            prev_done = done_o;
            begin
                bit mr;
                mr = (q.size() == 0 && !mclk) || (q.size() != 0 && q[0].ph == 5);
                chk(ready_o == mr, "R2", "ready_o", 32'(ready_o), 32'(mr));
                if (q.size() != 0) void'(q.pop_front());
                if (req_i && mr) begin
                    cyc_t c;
                    int np;
                    np = req_int_term_i ? int'(req_wait_i) + 1 : tb_ext + 1;
                    c.pairs = np; c.addr = req_addr_i; c.size = req_size_i;
                    c.wr = req_write_i; c.wdata = req_wdata_i; c.intm = req_int_term_i;
                    c.rdat = tb_rdat;
                    c.fin = 0; c.ta_low = 0;
                    c.ph = 0; q.push_back(c);
                    c.ph = 1; q.push_back(c);
                    for (int p = 0; p < np; p++) begin
                        c.fin = 0;
                        c.ph = 2; c.ta_low = tb_glitch && p == 0 && np > 1; q.push_back(c);
                        c.ph = 3; c.fin = (p == np - 1);
                        c.ta_low = c.fin ? !c.intm : (tb_early && p == 0);
                        q.push_back(c);
                    end
                    c.fin = 0;
                    c.ph = 4; c.ta_low = !c.intm; q.push_back(c);
                    c.ph = 5; c.ta_low = 0; q.push_back(c);
                end
            end
            mclk = ~mclk;
        end
    end

    task automatic issue(input logic [31:0] a, input logic [1:0] s, input logic w,
                         input logic [31:0] wd, input logic im, input int wt,
                         input int ext, input bit early, input bit glitch,
                         input logic [31:0] rd);
        req_addr_i = a; req_size_i = s; req_write_i = w; req_wdata_i = wd;
        req_int_term_i = im; req_wait_i = 4'(wt);
        tb_ext = ext; tb_early = early; tb_glitch = glitch; tb_rdat = rd;
        req_i = 1'b1;
        forever begin
            @(negedge clk);
            if (ready_o) begin
                @(posedge clk);
                #1;
                req_i = 1'b0;
                break;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk({ts_n_o, tip_n_o, cs_n_o, oe_n_o, ta_int_n_o} == 5'h1F && be_n_o == 4'hF,
            "R1", "reset strobes", 32'({ts_n_o, tip_n_o, cs_n_o, oe_n_o, be_n_o}), 32'h1FF);
        chk(!addr_oe_o && !data_oe_o && !bus_clk_o && rnw_o, "R1", "reset drives",
            32'({addr_oe_o, data_oe_o, bus_clk_o, rnw_o}), 32'b0001);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        started = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        // R6 R7: external read, no wait
        issue(32'h1000_0000, 2'd2, 0, 0, 0, 9, 0, 0, 0, 32'hCAFE_0001);
        repeat (12) @(posedge clk);
        #1;
        // R6: external read, 3 waits, ack glitch in S2 ignored, byte lane
        issue(32'h1000_0101, 2'd0, 0, 0, 0, 0, 3, 0, 1, 32'h1234_5678);
        repeat (9) @(posedge clk);
        #1;
        // R11 R5: external half-word write, one wait
        issue(32'h2000_0002, 2'd1, 1, 32'hA5A5_5A5A, 0, 0, 1, 0, 0, 0);
        repeat (7) @(posedge clk);
        #1;
        // R8: internal termination, W=0 and W=5 with early ack ignored, W=15 write
        issue(32'h3000_0000, 2'd3, 0, 0, 1, 0, 0, 0, 0, 32'h0BAD_F00D);
        repeat (6) @(posedge clk);
        #1;
        issue(32'h3000_0010, 2'd2, 0, 0, 1, 5, 0, 1, 1, 32'h5555_AAAA);
        repeat (5) @(posedge clk);
        #1;
        issue(32'h3000_0020, 2'd2, 1, 32'hDEAD_BEEF, 1, 15, 0, 1, 0, 0);
        repeat (10) @(posedge clk);
        #1;
        // R10 R5: back-to-back byte reads on every lane, then a write
        for (int k = 0; k < 4; k++)
            issue(32'h4000_0000 + k, 2'd0, 0, 0, k[0], k, 2, 0, 0, 32'h7700_0000 + k);
        issue(32'h4000_0006, 2'd1, 1, 32'h0102_0304, 0, 0, 0, 0, 0, 0);
        issue(32'h4000_0008, 2'd2, 0, 0, 0, 0, 1, 0, 0, 32'hFEED_FACE);
        repeat (40) @(posedge clk);
        #1;
        // R10: transfers starting directly in S5
        chk(b2b_seen >= 5, "R10", "back-to-back starts", 32'(b2b_seen), 32'd5);
        chk(q.size() == 0, "R9", "model drained", 32'(q.size()), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule